// File: doc/BRIEF.md
# Reloading Prescaler with Event Counter

This block divides a slow tick stream by a value set by software and counts how many times that division completes. A down-counter (the divider count) drops by one on each tick. One tick after it has reached zero, it refills from a software reload value. An event counter advances in that same refill tick, so software can read elapsed divided periods from one 32-bit register.

The tick comes from one of two sources. It can come from an internal divider of the system clock, which gives a 20 MHz tick rate by default. Or it can come straight from an input pin, chosen by a parameter. Software reaches the reload value, the divider count and the event counter through a flat register port. The port has a write strobe with a select and data, and a combinational read selected by an index. A reload value of zero is a legal setting. In that case the divider count parks at zero and the event counter advances on every tick.

Top module: `tick_prescaler`

## Requirements
- R1: After reset the reload value, divider count and event counter all read as zero.
- R2: On a tick with a nonzero divider count and no write, the divider count decreases by one and the event counter holds.
- R3: On a tick with the divider count at zero, the divider count loads the reload value and the event counter rises by one in that same cycle. With reload 5 and a starting count of 7, fourteen ticks leave the count at 5 with two increments.
- R4: With a reload value of zero, the divider count stays at zero and the event counter rises on every tick.
- R5: In a cycle with neither a tick nor a write, all three registers hold.
- R6: A write to the divider count or the event counter is visible the next cycle, and later ticks count on from the written value.
- R7: A reload write changes only the reload value. The running divider count keeps counting down and takes the new value at its next refill.
- R8: When a write and a tick fall in the same cycle, the written register takes the written data. The other registers take their tick update, computed from the values held before the write, including the old reload value.
- R9: The event counter wraps from all ones to zero with no other effect.
- R10: Select encoding for both read and write: 0 is the reload value, 1 the divider count, 2 the event counter. Select 3 reads zero, and a write to it changes nothing.
- R11: With the internal tick source, tick_o pulses for one cycle once every SYS_HZ/TICK_HZ system clocks, and ext_tick_i has no effect.
- R12: With the external tick source, tick_o follows ext_tick_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | Single-cycle tick enable, used when the external source is selected |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select (0 reload, 1 divider count, 2 event counter) |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | DATA_W | Selected register value |
| tick_o | output | 1 | The tick in use by the counters |

## Verification
A software write and a tick can land in the same clock, and the collision matters most when the divider count is at zero and about to refill. The bench drives ticks and writes together to each target at that point: a write to the event counter during a refill, a reload write during a refill, and a divider count write mid-countdown. A behavioural reference model compares all three registers after every clock. The model applies the tick from the old values first and then lets the write replace only its own register.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int unsigned TP_DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_DIVCNT = 2'd1,
        SEL_EVCNT  = 2'd2,
        SEL_NONE   = 2'd3
    } tp_sel_e;
endpackage

// File: rtl/tp_tick_gen.sv
module tp_tick_gen #(
    parameter int unsigned DIV      = 5,
    parameter bit          EXT_TICK = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_tick_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             div_tick;

    assign div_tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = div_tick ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    generate
        if (EXT_TICK) begin : g_ext
            assign tick_o = ext_tick_i | (div_tick & 1'b0);
        end else begin : g_int
            assign tick_o = div_tick | (ext_tick_i & 1'b0);
        end
    endgenerate
endmodule

// File: rtl/tp_readmux.sv
module tp_readmux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic [DATA_W-1:0] divcnt_i,
    input  logic [DATA_W-1:0] evcnt_i,
    output logic [DATA_W-1:0] data_o
);
    import tp_pkg::*;

    always_comb begin
        unique case (tp_sel_e'(sel_i))
            SEL_RELOAD: data_o = reload_i;
            SEL_DIVCNT: data_o = divcnt_i;
            SEL_EVCNT:  data_o = evcnt_i;
            default:    data_o = '0;
        endcase
    end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned DATA_W   = tp_pkg::TP_DATA_W,
    parameter int unsigned SYS_HZ   = 100_000_000,
    parameter int unsigned TICK_HZ  = 20_000_000,
    parameter bit          EXT_TICK = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              tick_o
);
    import tp_pkg::*;

    localparam int unsigned DIV = (SYS_HZ / TICK_HZ > 0) ? SYS_HZ / TICK_HZ : 1;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] divcnt;
        logic [DATA_W-1:0] evcnt;
    } tp_state_t;

    tp_state_t         st_d, st_q;
    logic              tick;
    logic [DATA_W-1:0] reload_q, divcnt_q, evcnt_q;

    tp_tick_gen #(
        .DIV      (DIV),
        .EXT_TICK (EXT_TICK)
    ) i_tick_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ext_tick_i (ext_tick_i),
        .tick_o     (tick)
    );

    assign tick_o = tick;

    // Tick update first, from held values; a write then overrides its own target.
    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.divcnt != '0) begin
                st_d.divcnt = st_q.divcnt - ONE;
            end else begin
                st_d.divcnt = st_q.reload;
                st_d.evcnt  = st_q.evcnt + ONE;
            end
        end
        if (wr_en_i) begin
            unique case (tp_sel_e'(wr_sel_i))
                SEL_RELOAD: st_d.reload = wr_data_i;
                SEL_DIVCNT: st_d.divcnt = wr_data_i;
                SEL_EVCNT:  st_d.evcnt  = wr_data_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign reload_q = st_q.reload;
    assign divcnt_q = st_q.divcnt;
    assign evcnt_q  = st_q.evcnt;

    tp_readmux #(
        .DATA_W (DATA_W)
    ) i_readmux (
        .sel_i    (rd_sel_i),
        .reload_i (reload_q),
        .divcnt_i (divcnt_q),
        .evcnt_i  (evcnt_q),
        .data_o   (rd_data_o)
    );
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] reload,
    input logic [DATA_W-1:0] divcnt,
    input logic [DATA_W-1:0] evcnt
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && divcnt != '0) |=>
        (divcnt == $past(divcnt) - ONE && evcnt == $past(evcnt)));

    a_r3_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && divcnt == '0) |=>
        (divcnt == $past(reload) && evcnt == $past(evcnt) + ONE));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=>
        ($stable(divcnt) && $stable(evcnt) && $stable(reload)));

    a_r6_evcnt_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (evcnt == $past(wr_data)));

    a_r7_reload_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !tick) |=>
        ($stable(divcnt) && $stable(evcnt) && reload == $past(wr_data)));

    a_r10_null_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !tick) |=>
        ($stable(divcnt) && $stable(evcnt) && $stable(reload)));
endmodule

bind tick_prescaler tp_checker #(.DATA_W(DATA_W)) i_tp_checker (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .tick    (tick_o),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .reload  (reload_q),
    .divcnt  (divcnt_q),
    .evcnt   (evcnt_q)
);

// File: tb/test_tick_prescaler.sv
`timescale 1ns/1ps
module test_tick_prescaler;
    localparam int unsigned W        = 32;
    localparam int unsigned SYS      = 100_000_000;
    localparam int unsigned TICKRATE = 20_000_000;
    localparam int          EXP_GAP  = SYS / TICKRATE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [W-1:0]  wr_data = '0;
    logic [1:0]    rd_sel = 2'd0;
    logic [W-1:0]  rd_data, rd_data_div;
    logic          tick_out, tick_div;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit [31:0] m_rel = 0, m_div = 0, m_ev = 0;

    always #2.5 clk = ~clk;

    tick_prescaler #(.DATA_W(W), .SYS_HZ(SYS), .TICK_HZ(TICKRATE), .EXT_TICK(1'b1)) i_tick_prescaler (
        .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(ext_tick), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .tick_o(tick_out));

    tick_prescaler #(.DATA_W(W), .SYS_HZ(SYS), .TICK_HZ(TICKRATE), .EXT_TICK(1'b0)) i_tick_prescaler_div (
        .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(ext_tick), .wr_en_i(1'b0),
        .wr_sel_i(2'd0), .wr_data_i('0), .rd_sel_i(2'd1),
        .rd_data_o(rd_data_div), .tick_o(tick_div));

    task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        rd_sel = 2'd0; #0.3; check(tag, "reload", rd_data, m_rel);
        rd_sel = 2'd1; #0.3; check(tag, "divcnt", rd_data, m_div);
        rd_sel = 2'd2; #0.3; check(tag, "evcnt",  rd_data, m_ev);
        rd_sel = 2'd3; #0.3; check("R10", "select3", rd_data, '0);
    endtask

    // Drive one clock of stimulus, advance the reference model, compare.
    task automatic cyc(input string tag, input bit t, input bit w, input logic [1:0] s, input logic [W-1:0] d);
        bit [31:0] n_rel, n_div, n_ev;
        ext_tick = t; wr_en = w; wr_sel = s; wr_data = d;
        #0.1;
        check("R12", "tick_o", {31'd0, tick_out}, {31'd0, t});
        n_rel = m_rel; n_div = m_div; n_ev = m_ev;
        if (t) begin
            if (m_div != 0) n_div = m_div - 1;
            else begin n_div = m_rel; n_ev = m_ev + 1; end
        end
        if (w) begin
            if (s == 2'd0) n_rel = d;
            else if (s == 2'd1) n_div = d;
            else if (s == 2'd2) n_ev = d;
        end
        @(posedge clk);
        m_rel = n_rel; m_div = n_div; m_ev = n_ev;
        @(negedge clk);
        ext_tick = 1'b0; wr_en = 1'b0;
        compare(tag);
    endtask

    // Internal divider: pulse spacing of the default-source instance (R11).
    int cyc_no = 0, last_pulse = -1, gap_checks = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc_no++;
            if (tick_div) begin
                if (last_pulse >= 0 && gap_checks < 20) begin
                    gap_checks++;
                    check("R11", "tick gap", W'(cyc_no - last_pulse), W'(EXP_GAP));
                end
                last_pulse = cyc_no;
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        for (int i = 0; i < 5; i++) cyc("R4", 1'b1, 1'b0, 2'd0, '0);
        check("R4", "evcnt after 5 ticks", m_ev, 32'd5);
        for (int i = 0; i < 3; i++) cyc("R5", 1'b0, 1'b0, 2'd0, '0);

        cyc("R7", 1'b0, 1'b1, 2'd0, 32'd5);
        cyc("R6", 1'b0, 1'b1, 2'd1, 32'd7);
        for (int i = 0; i < 14; i++) cyc("R3", 1'b1, 1'b0, 2'd0, '0);
        rd_sel = 2'd1; #0.3; check("R3", "divcnt after 14", rd_data, 32'd5);
        rd_sel = 2'd2; #0.3; check("R3", "evcnt after 14", rd_data, 32'd7);

        for (int i = 0; i < 2; i++) cyc("R2", 1'b1, 1'b0, 2'd0, '0);
        cyc("R7", 1'b0, 1'b1, 2'd0, 32'd2);
        for (int i = 0; i < 8; i++) cyc("R7", (i % 3) != 1, 1'b0, 2'd0, '0);

        cyc("R6", 1'b0, 1'b1, 2'd2, 32'd100);
        for (int i = 0; i < 6; i++) cyc("R6", 1'b1, 1'b0, 2'd0, '0);

        cyc("R8", 1'b0, 1'b1, 2'd1, 32'd0);
        cyc("R8", 1'b1, 1'b1, 2'd2, 32'd50);
        check("R8", "evcnt write wins", m_ev, 32'd50);
        cyc("R8", 1'b0, 1'b1, 2'd1, 32'd0);
        cyc("R8", 1'b1, 1'b1, 2'd0, 32'd9);
        check("R8", "old reload used", m_div, 32'd2);
        cyc("R8", 1'b1, 1'b1, 2'd1, 32'd3);
        for (int i = 0; i < 12; i++) cyc("R8", 1'b1, 1'b0, 2'd0, '0);

        cyc("R9", 1'b0, 1'b1, 2'd0, 32'd0);
        cyc("R9", 1'b0, 1'b1, 2'd1, 32'd0);
        cyc("R9", 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        cyc("R9", 1'b1, 1'b0, 2'd0, '0);
        rd_sel = 2'd2; #0.3; check("R9", "evcnt wrap", rd_data, 32'd0);

        cyc("R10", 1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF);
        cyc("R10", 1'b1, 1'b1, 2'd3, 32'h1234_5678);

        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ext_tick = i[0];
        end
        ext_tick = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule